// File: doc/BRIEF.md
# Bitplane Video Pixel Shifter

The block converts interleaved bitplane video data into a stream of per-pixel colour indices. Sixteen-bit words arrive one at a time, each qualified by a load strobe, and are gathered into a four-word holding store. When the fourth word of a group arrives, all four words move in parallel into four 16-bit shift registers in that same clock, so groups follow each other with no idle cycle. Each shift register feeds one bit of the colour index, most significant pixel first.

A 2-bit shift mode selects how the shift registers are chained and how often they advance. In low resolution the four registers shift on their own every fourth clock and give a 4-bit index. In medium resolution they are linked in pairs, shift every second clock and give a 2-bit index. In high resolution they form one 64-bit chain that shifts every clock, and only index bit 0 carries the monochrome pixel. The fourth code stops shifting. Index bits that a mode does not use are passed through unchanged, and a separate mask output tells downstream palette logic which bits are valid.

The mode is written over a small host port with an active-low select. The value is captured when the select returns high and drives the shifter two clocks later. A line-start input restarts the load-group count and the shift divider. If a line ends with an incomplete group and no line-start pulse follows, the leftover words stay in the holding store and lead the next transfer.

Top module: `bitplane_shifter`

## Requirements
- R1: A load strobe stores the word in the next slot (0, 1, 2) of the holding store. Until the fourth load of a group, the colour index output changes only through shifting of the data already in the shift registers.
- R2: On the clock edge of the fourth load of a group, the shift registers take words 0..3 of the group in parallel (word k feeds index bit k, the word on the fourth load is word 3). The next load starts a new group at slot 0.
- R3: With mode 2'b00 (low resolution), index bit k is bit 15-n of word k for pixel n (n = 0..15), and the output advances once every 4 clocks.
- R4: With mode 2'b01 (medium resolution), for pixel n (0..31) index bit 0 comes from word 0 (n < 16) or word 2 (n >= 16) and bit 1 from word 1 or word 3, most significant bit first, and the output advances once every 2 clocks.
- R5: With mode 2'b10 (high resolution), index bit 0 of pixel n (0..63) is bit 15-(n mod 16) of word n/16, and the output advances every clock.
- R6: The valid mask is 4'b1111, 4'b0011, 4'b0001 and 4'b0000 for modes 2'b00, 2'b01, 2'b10 and 2'b11. Unused index bits are not forced to zero: in medium mode, index bits 3:2 of pixel 0 are bit 15 of words 3 and 2.
- R7: Mode 2'b11 stops shifting: the shift strobe stays low and the colour index holds its value.
- R8: The mode value is the host data on the last clock with the select low. It is stored on the first clock edge that sees the select high again, and the mask and shift rate change two clocks after that edge.
- R9: When the effective mode changes, and on a line-start pulse, the shift divider restarts: the first shift strobe comes in the 4th, 2nd or 1st clock for low, medium or high mode.
- R10: Without a line-start pulse, a group that holds three words when a line ends is completed by the first word of the next line, so the three leftover words form planes 0..2 of the next transfer. A line-start pulse discards the partial group.
- R11: After synchronous reset, the shift registers and the holding store are zero, the mode is low resolution and the group count is at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| lineSync | input | 1 | Line-start pulse: clears the group count and the divider |
| loadStb | input | 1 | Qualifies wordIn for one clock |
| wordIn | input | 16 | Bitplane video word |
| hostSelN | input | 1 | Active-low select of the mode register |
| hostData | input | 2 | Mode value written while selected |
| pixIdx | output | 4 | Colour index of the current pixel |
| pixMask | output | 4 | Bits of pixIdx valid in the current mode |
| pixStrobe | output | 1 | High in clocks where the shifter advances at the next edge |

## Verification
The bench sweeps every mode over several word patterns and compares each pixel of the stream with values it works out from the bit positions, so a swapped plane, a wrong pair chaining or a wrong chain order in high mode shows up as a wrong index at a known pixel. It measures the mode-change latency clock by clock after the select is released: a design that uses the mode at once, or one clock late, shows the new mask too early or too late. It checks where the divider restarts after a mode change and after a line-start pulse, and that the stop code freezes the index. Short lines are run with and without the line-start pulse. A design that clears leftovers by itself, or keeps them after a resync, sends the wrong words to the first transfer of the next line.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  localparam int WORD_W  = 16;
  localparam int PLANES  = 4;
  localparam int GRP_W   = $clog2(PLANES);
  localparam int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_LOW  = 2'b00,
    MODE_MED  = 2'b01,
    MODE_HIGH = 2'b10,
    MODE_STOP = 2'b11
  } mode_e;

  typedef struct packed {
    logic             load;
    logic [GRP_W-1:0] slot;
    logic             xfer;
    logic             shift;
    mode_e            mode;
  } strobes_t;
endpackage

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import shifter_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        lineSync,
  input  logic        loadStb,
  input  logic        hostSelN,
  input  logic [1:0]  hostData,
  output strobes_t    stb
);
  logic             selPrev;
  mode_e            dataHold, modeReg, modeDly, modeEff;
  logic [GRP_W-1:0] grpCnt, slotNow;
  logic [1:0]       divCnt, divLim;
  logic             shiftEn;

  // host write: data of the last selected clock, stored on select release
  always_ff @(posedge clk) begin
    if (rst) begin
      selPrev  <= 1'b1;
      dataHold <= MODE_LOW;
      modeReg  <= MODE_LOW;
      modeDly  <= MODE_LOW;
      modeEff  <= MODE_LOW;
    end else begin
      selPrev <= hostSelN;
      if (!hostSelN) dataHold <= mode_e'(hostData);
      if (hostSelN && !selPrev) modeReg <= dataHold;
      modeDly <= modeReg;
      modeEff <= modeDly;
    end
  end

  // load-group counter
  assign slotNow = lineSync ? '0 : grpCnt;

  always_ff @(posedge clk) begin
    if (rst)          grpCnt <= '0;
    else if (loadStb) grpCnt <= slotNow + 1'b1;
    else if (lineSync) grpCnt <= '0;
  end

  // shift divider
  always_comb begin
    case (modeEff)
      MODE_LOW: divLim = 2'd3;
      MODE_MED: divLim = 2'd1;
      default:  divLim = 2'd0;
    endcase
  end

  assign shiftEn = (modeEff != MODE_STOP) && (divCnt == divLim);

  always_ff @(posedge clk) begin
    if (rst)                                       divCnt <= '0;
    else if (lineSync || (modeDly != modeEff) || shiftEn) divCnt <= '0;
    else                                           divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    stb.load  = loadStb;
    stb.slot  = slotNow;
    stb.xfer  = loadStb && (slotNow == GRP_W'(PLANES - 1));
    stb.shift = shiftEn;
    stb.mode  = modeEff;
  end
endmodule

// File: rtl/shifter_data.sv
module shifter_data
  import shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [WORD_W-1:0] wordIn,
  output logic [PLANES-1:0] pixIdx
);
  localparam int HOLD_N = PLANES - 1;

  logic [HOLD_N-1:0][WORD_W-1:0] holdReg;
  logic [PLANES-1:0][WORD_W-1:0] shReg;
  logic [PLANES-1:0]             feedBit;

  // holding store: the last word of a group bypasses it
  always_ff @(posedge clk) begin
    if (rst) holdReg <= '0;
    else if (stb.load && !stb.xfer) holdReg[stb.slot] <= wordIn;
  end

  // chaining feed per mode
  always_comb begin
    for (int k = 0; k < PLANES; k++) begin
      feedBit[k] = 1'b0;
      case (stb.mode)
        MODE_MED:  if (k + 2 < PLANES) feedBit[k] = shReg[k + 2][WORD_W-1];
        MODE_HIGH: if (k + 1 < PLANES) feedBit[k] = shReg[k + 1][WORD_W-1];
        default:   feedBit[k] = 1'b0;
      endcase
    end
  end

  for (genvar k = 0; k < PLANES; k++) begin : g_plane
    always_ff @(posedge clk) begin
      if (rst)            shReg[k] <= '0;
      else if (stb.xfer)  shReg[k] <= (k == PLANES - 1) ? wordIn : holdReg[k % HOLD_N];
      else if (stb.shift) shReg[k] <= {shReg[k][WORD_W-2:0], feedBit[k]};
    end
    assign pixIdx[k] = shReg[k][WORD_W-1];
  end
endmodule

// File: rtl/bitplane_shifter.sv
module bitplane_shifter
  import shifter_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        lineSync,
  input  logic        loadStb,
  input  logic [15:0] wordIn,
  input  logic        hostSelN,
  input  logic [1:0]  hostData,
  output logic [3:0]  pixIdx,
  output logic [3:0]  pixMask,
  output logic        pixStrobe
);
  strobes_t stb;

  shifter_ctrl u_ctrl (
    .clk(clk), .rst(rst), .lineSync(lineSync), .loadStb(loadStb),
    .hostSelN(hostSelN), .hostData(hostData), .stb(stb)
  );

  shifter_data u_data (
    .clk(clk), .rst(rst), .stb(stb), .wordIn(wordIn), .pixIdx(pixIdx)
  );

  always_comb begin
    case (stb.mode)
      MODE_LOW:  pixMask = 4'b1111;
      MODE_MED:  pixMask = 4'b0011;
      MODE_HIGH: pixMask = 4'b0001;
      default:   pixMask = 4'b0000;
    endcase
  end

  assign pixStrobe = stb.shift;
endmodule

// File: rtl/shifter_chk.sv
module shifter_chk (
  input logic       clk,
  input logic       rst,
  input logic       loadStb,
  input logic [3:0] pixIdx,
  input logic [3:0] pixMask,
  input logic       pixStrobe
);
  AST_MASK_CODE: assert property (@(posedge clk) disable iff (rst)
    (pixMask == 4'hF) || (pixMask == 4'h3) || (pixMask == 4'h1) || (pixMask == 4'h0)); // R6

  AST_STOP_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (pixMask == 4'h0) |-> !pixStrobe); // R7

  AST_HIGH_EVERY_CLK: assert property (@(posedge clk) disable iff (rst)
    (pixMask == 4'h1) |-> pixStrobe); // R5

  AST_LOW_GAP: assert property (@(posedge clk) disable iff (rst)
    (pixStrobe && pixMask == 4'hF) |=> (pixMask != 4'hF || !pixStrobe)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pixStrobe && !loadStb) |=> $stable(pixIdx)); // R1
endmodule

bind bitplane_shifter shifter_chk u_chk (
  .clk(clk), .rst(rst), .loadStb(loadStb),
  .pixIdx(pixIdx), .pixMask(pixMask), .pixStrobe(pixStrobe)
);

// File: tb/sim_bitplane_shifter.sv
module sim_bitplane_shifter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, lineSync, loadStb, hostSelN;
  logic [15:0] wordIn;
  logic [1:0]  hostData;
  logic [3:0]  pixIdx, pixMask;
  logic        pixStrobe;
  int checks = 0, errors = 0;
  bit done = 0;

  bitplane_shifter u0 (
    .clk(clk), .rst(rst), .lineSync(lineSync), .loadStb(loadStb), .wordIn(wordIn),
    .hostSelN(hostSelN), .hostData(hostData),
    .pixIdx(pixIdx), .pixMask(pixMask), .pixStrobe(pixStrobe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] maskOf(input int m);
    case (m)
      0: return 4'hF;
      1: return 4'h3;
      2: return 4'h1;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [3:0] expPix(input int m, input int n, input logic [63:0] pk);
    logic [3:0] r = '0;
    int p;
    if (m == 0) begin
      for (int k = 0; k < 4; k++) r[k] = pk[k*16 + 15 - n];
    end else if (m == 1) begin
      p = n % 16;
      r[0] = pk[(n < 16 ? 0 : 32) + 15 - p];
      r[1] = pk[(n < 16 ? 16 : 48) + 15 - p];
    end else begin
      r[0] = pk[(n / 16) * 16 + 15 - (n % 16)];
    end
    return r;
  endfunction

  task automatic syncPulse();
    @(negedge clk) lineSync = 1'b1;
    @(negedge clk) lineSync = 1'b0;
  endtask

  task automatic loadOne(input logic [15:0] w);
    @(negedge clk) begin loadStb = 1'b1; wordIn = w; end
    @(negedge clk) loadStb = 1'b0;
  endtask

  task automatic loadGroup(input logic [63:0] pk);
    syncPulse();
    for (int k = 0; k < 4; k++) begin
      loadStb = 1'b1;
      wordIn  = pk[k*16 +: 16];
      @(negedge clk);
    end
    loadStb = 1'b0;
  endtask

  task automatic collect(input int m, input logic [63:0] pk, input string req);
    int total = (m == 0) ? 16 : (m == 1) ? 32 : 64;
    logic [3:0] msk = maskOf(m);
    for (int n = 0; n < total; n++) begin
      chk(req, pixIdx & msk, expPix(m, n, pk) & msk);
      if (n < total - 1) begin
        for (int g = 0; g < 8 && !pixStrobe; g++) @(negedge clk);
        @(negedge clk);
      end
    end
  endtask

  task automatic countStrobes(input int expCnt, input string req);
    int c = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pixStrobe) c++;
    end
    chk(req, c, expCnt);
  endtask

  // R8 latency and R9 divider restart on every mode change
  task automatic setMode(input int m, input int oldM);
    int lim = (m == 0) ? 3 : (m == 1) ? 1 : 0;
    @(negedge clk) begin hostSelN = 1'b0; hostData = m[1:0]; end
    @(negedge clk) begin hostSelN = 1'b1; hostData = 2'b00; end
    @(negedge clk) chk("R8 mask one clock after capture", pixMask, maskOf(oldM));
    @(negedge clk) chk("R8 mask two clocks after release", pixMask, maskOf(oldM));
    @(negedge clk) chk("R8 mask after latency", pixMask, maskOf(m));
    if (m == 3) chk("R9 stop mode strobe", pixStrobe, 0);
    else begin
      for (int i = 0; i <= lim; i++) begin
        chk("R9 divider restart", pixStrobe, (i == lim));
        if (i < lim) @(negedge clk);
      end
    end
  endtask

  logic [63:0] pats [3];

  initial begin
    pats[0] = 64'h0F0F_3C3C_A5A5_8001;
    pats[1] = 64'hFFFF_0000_C001_7E81;
    pats[2] = 64'h1234_89AB_F00D_6E5A;
    rst = 1'b1; lineSync = 1'b0; loadStb = 1'b0; hostSelN = 1'b1;
    wordIn = '0; hostData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset index", pixIdx, 4'h0);
    chk("R11 reset mode mask", pixMask, 4'hF);
    countStrobes(2, "R3 low rate");

    // R1 / R10: partial group carried into next line
    syncPulse();
    loadOne(16'hA001); loadOne(16'h5002); loadOne(16'hC003);
    repeat (10) @(negedge clk);
    chk("R1 no transfer before fourth load", pixIdx, 4'h0);
    loadOne(16'h8FF4);
    collect(0, {16'h8FF4, 16'hC003, 16'h5002, 16'hA001}, "R10 leftover words lead next group");

    // R10: line-start pulse discards a partial group
    repeat (70) @(negedge clk);
    syncPulse();
    loadOne(16'hFFFF); loadOne(16'hFFFF); loadOne(16'hFFFF);
    loadGroup(pats[2]);
    collect(0, pats[2], "R10 resync discards partial group");

    // R9 line-start restarts divider
    syncPulse();
    for (int i = 0; i < 4; i++) begin
      chk("R9 divider after line start", pixStrobe, (i == 3));
      @(negedge clk);
    end

    // R2 / R3 low resolution sweep
    foreach (pats[i]) begin
      loadGroup(pats[i]);
      collect(0, pats[i], "R2 R3 low stream");
    end

    // R4 / R6 medium
    setMode(1, 0);
    countStrobes(4, "R4 medium rate");
    foreach (pats[i]) begin
      loadGroup(pats[i]);
      chk("R6 unused bits pass through", pixIdx[3:2], {pats[i][63], pats[i][47]});
      collect(1, pats[i], "R4 medium stream");
    end

    // R5 high
    setMode(2, 1);
    countStrobes(8, "R5 high rate");
    foreach (pats[i]) begin
      loadGroup(pats[i]);
      collect(2, pats[i], "R5 high stream");
    end

    // R7 stop
    setMode(3, 2);
    loadGroup(pats[1]);
    chk("R7 transfer in stop mode", pixIdx, expPix(0, 0, pats[1]));
    countStrobes(0, "R7 no strobes");
    chk("R7 index frozen", pixIdx, expPix(0, 0, pats[1]));
    chk("R6 stop mask", pixMask, 4'h0);

    setMode(0, 3);
    loadGroup(pats[0]);
    collect(0, pats[0], "R3 low after stop");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule